// File: doc/BRIEF.md
# Two-Channel Prescaled Interval Timer

This peripheral is an APB slave holding two timer channels that share nothing but the bus. Each channel divides a tick-enable strobe by a programmable ratio between 1 and 256. It counts the resulting ticks in a 16-bit up-counter and compares the count against a software-chosen interval. When the interval is reached the channel latches a match flag. It then either restarts from zero (periodic operation) or switches itself off and freezes the count (one-shot operation).

Each channel drives its own interrupt line, which is high while the latched flag and the channel's interrupt enable are both set. Software clears the flag by writing a one to it. The timer clock is the bus clock qualified by `tick_en`, so no clock-domain crossing is involved. New interval and divider values written while a channel runs are held in a shadow copy. They become active at the next match and the next divider wrap respectively.

Channel c occupies a 32-byte window at byte address c*0x20. Inside that window: word 0x0 is control (bit 0 run, bit 1 one-shot when 1 / periodic when 0, bit 2 interrupt enable), word 0x4 is status (bit 0 match flag), word 0x8 is the interval (16 bits), word 0xC is the current count (read-only), and word 0x10 is the divider setting N (8 bits, divide by N+1).

Top module: `dual_timer_apb`

## Requirements
- R1: After reset every register of both channels reads 0 and both interrupt lines are low.
- R2: Control, interval and divider registers read back the last value written, limited to their defined bits; writes to the count register are ignored.
- R3: With divider setting N, a running channel's count advances once per N+1 cycles in which `tick_en` is high; a divider of 2 with interval 5 and `tick_en` held high sets the flag 15 cycles after the enabling write.
- R4: Setting the run bit on a stopped channel clears its count to zero, and the count advances only in cycles where `tick_en` is high.
- R5: The match flag sets on the tick that brings the count to the interval; an interval of 0 matches after 65536 ticks.
- R6: In periodic mode a match returns the count to zero and the channel keeps running.
- R7: In one-shot mode a match clears the run bit and leaves the count equal to the interval.
- R8: Each interrupt line equals its channel's match flag ANDed with its interrupt enable, on every cycle.
- R9: Writing 1 to status bit 0 clears the flag, writing 0 leaves it alone, and a match in the same cycle as the clearing write keeps the flag set.
- R10: An interval or divider written while the channel runs becomes active only at the next match or divider wrap; while stopped it becomes active at once.
- R11: Clearing the run bit holds the count and returns the divider phase to zero.
- R12: The two channels operate independently under any mix of settings.
- R13: PREADY is always high; PSLVERR is high in the access phase of a transfer to an unmapped or misaligned offset, such a read returns 0 and such a write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| tick_en | input | 1 | Timer tick qualifier |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Access to an unmapped offset |
| irq | output | N_CH | Per-channel match interrupt |

## Verification
The hardest case to reach is a flag-clearing write that lands on the exact cycle of a new match, because a match is normally a rare event set by the divider phase. The bench forces it by running a channel with divide-by-one and an interval of one, so every cycle is a match and any clearing write must coincide with a set. A bench reference model compares both interrupt lines on every clock while random `tick_en` patterns drive both channels. Directed runs time the first match exactly, including the 65536-tick wrap of an interval of zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W    = 16;
    localparam int PSC_W    = 8;
    localparam int DATA_W   = 32;
    localparam int CH_SHIFT = 5;
    localparam int SEL_W    = 3;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_OS  = 1;
    localparam int CTRL_IE  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_STAT = 3'd1,
        SEL_IVAL = 3'd2,
        SEL_CNT  = 3'd3,
        SEL_DIV  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [PSC_W-1:0] phase;
        logic [PSC_W-1:0] div_act;
        logic [PSC_W-1:0] div_sh;
    } div_state_t;

    typedef struct packed {
        logic             run;
        logic             oneshot;
        logic             ie;
        logic             flag;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ival_act;
        logic [CNT_W-1:0] ival_sh;
    } chn_state_t;
endpackage

// File: rtl/tmr_apb_decode.sv
module tmr_apb_decode
    import tmr_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int ADDR_W = 8,
    localparam int CH_W  = ADDR_W - CH_SHIFT
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              bad,
    output logic [CH_W-1:0]   ch_idx,
    output reg_sel_e          sel
);
    logic access;
    logic mapped;
    logic ch_in_range;

    assign access      = psel && penable;
    assign ch_idx      = paddr[ADDR_W-1:CH_SHIFT];
    assign sel         = reg_sel_e'(paddr[CH_SHIFT-1:2]);
    assign ch_in_range = (32'(ch_idx) < 32'(N_CH));
    assign mapped      = ch_in_range && (paddr[1:0] == 2'b00)
                         && (paddr[CH_SHIFT-1:2] <= SEL_DIV);

    assign wr_ok = access && mapped && pwrite;
    assign rd_ok = access && mapped && !pwrite;
    assign bad   = access && !mapped;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic             wr_div,
    input  logic [PSC_W-1:0] wr_val,
    output logic             tick,
    output logic [PSC_W-1:0] div_shadow
);
    div_state_t s_d, s_q;
    logic       wrap;

    assign wrap       = (s_q.phase == s_q.div_act);
    assign tick       = run && tick_en && wrap;
    assign div_shadow = s_q.div_sh;

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.phase   = '0;
            s_d.div_act = s_q.div_sh;
        end else if (tick_en) begin
            if (wrap) begin
                s_d.phase   = '0;
                s_d.div_act = s_q.div_sh;
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
        if (wr_div) begin
            s_d.div_sh = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: the phase never passes the active divider setting
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase <= s_q.div_act);

    // R11: a stopped channel restarts its divider phase from zero
    p_idle_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> s_q.phase == '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic              wr_ival,
    input  logic              wr_div,
    input  logic [CNT_W-1:0]  wdata,
    output logic [DATA_W-1:0] rd_ctrl,
    output logic [DATA_W-1:0] rd_stat,
    output logic [DATA_W-1:0] rd_ival,
    output logic [DATA_W-1:0] rd_cnt,
    output logic [DATA_W-1:0] rd_div,
    output logic              irq
);
    chn_state_t       s_d, s_q;
    logic             tick;
    logic             match;
    logic [CNT_W-1:0] nxt;
    logic [PSC_W-1:0] div_shadow;

    tmr_prescaler u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (s_q.run),
        .tick_en    (tick_en),
        .wr_div     (wr_div),
        .wr_val     (wdata[PSC_W-1:0]),
        .tick       (tick),
        .div_shadow (div_shadow)
    );

    assign nxt = s_q.cnt + 1'b1;

    always_comb begin
        s_d   = s_q;
        match = 1'b0;
        if (!s_q.run) begin
            s_d.ival_act = s_q.ival_sh;
        end else if (tick) begin
            if (nxt == s_q.ival_act) begin
                match        = 1'b1;
                s_d.ival_act = s_q.ival_sh;
                if (s_q.oneshot) begin
                    s_d.cnt = nxt;
                    s_d.run = 1'b0;
                end else begin
                    s_d.cnt = '0;
                end
            end else begin
                s_d.cnt = nxt;
            end
        end
        if (wr_stat && wdata[0]) begin
            s_d.flag = 1'b0;
        end
        if (match) begin
            s_d.flag = 1'b1;
        end
        if (wr_ctrl) begin
            s_d.run     = wdata[CTRL_RUN];
            s_d.oneshot = wdata[CTRL_OS];
            s_d.ie      = wdata[CTRL_IE];
            if (wdata[CTRL_RUN] && !s_q.run) begin
                s_d.cnt = '0;
            end
        end
        if (wr_ival) begin
            s_d.ival_sh = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq     = s_q.flag && s_q.ie;
    assign rd_ctrl = {{(DATA_W-3){1'b0}}, s_q.ie, s_q.oneshot, s_q.run};
    assign rd_stat = {{(DATA_W-1){1'b0}}, s_q.flag};
    assign rd_ival = {{(DATA_W-CNT_W){1'b0}}, s_q.ival_sh};
    assign rd_cnt  = {{(DATA_W-CNT_W){1'b0}}, s_q.cnt};
    assign rd_div  = {{(DATA_W-PSC_W){1'b0}}, div_shadow};

    // R4: ticks come only from a running channel on a qualified cycle
    p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (s_q.run && tick_en));

    // R5: a match always leaves the flag set
    p_flag_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> s_q.flag);

    // R6: periodic match restarts from zero and keeps running
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !s_q.oneshot && !wr_ctrl) |=> (s_q.cnt == '0 && s_q.run));

    // R7: one-shot match stops the channel at the interval
    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && s_q.oneshot && !wr_ctrl) |=> (!s_q.run && s_q.cnt == $past(s_q.ival_act)));

    // R9: a clearing write without a coincident match drops the flag
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[0] && !match) |=> !s_q.flag);

    // R11: a stopped channel keeps its count
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !wr_ctrl) |=> $stable(s_q.cnt));
endmodule

// File: rtl/dual_timer_apb.sv
module dual_timer_apb
    import tmr_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int ADDR_W = 8,
    localparam int CH_W  = ADDR_W - CH_SHIFT
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              tick_en,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [N_CH-1:0]   irq
);
    logic            wr_ok;
    logic            rd_ok;
    logic            bad;
    logic [CH_W-1:0] ch_idx;
    reg_sel_e        sel;
    logic            unused_wdata_hi;

    logic [DATA_W-1:0] rd_ctrl [N_CH];
    logic [DATA_W-1:0] rd_stat [N_CH];
    logic [DATA_W-1:0] rd_ival [N_CH];
    logic [DATA_W-1:0] rd_cnt  [N_CH];
    logic [DATA_W-1:0] rd_div  [N_CH];

    assign unused_wdata_hi = ^pwdata[DATA_W-1:CNT_W];

    tmr_apb_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .bad     (bad),
        .ch_idx  (ch_idx),
        .sel     (sel)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_ok && (ch_idx == CH_W'(c));

        tmr_channel u_chn (
            .clk     (pclk),
            .rst_n   (presetn),
            .tick_en (tick_en),
            .wr_ctrl (hit && sel == SEL_CTRL),
            .wr_stat (hit && sel == SEL_STAT),
            .wr_ival (hit && sel == SEL_IVAL),
            .wr_div  (hit && sel == SEL_DIV),
            .wdata   (pwdata[CNT_W-1:0]),
            .rd_ctrl (rd_ctrl[c]),
            .rd_stat (rd_stat[c]),
            .rd_ival (rd_ival[c]),
            .rd_cnt  (rd_cnt[c]),
            .rd_div  (rd_div[c]),
            .irq     (irq[c])
        );
    end

    always_comb begin
        prdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (rd_ok && ch_idx == CH_W'(c)) begin
                case (sel)
                    SEL_CTRL: prdata = rd_ctrl[c];
                    SEL_STAT: prdata = rd_stat[c];
                    SEL_IVAL: prdata = rd_ival[c];
                    SEL_CNT:  prdata = rd_cnt[c];
                    SEL_DIV:  prdata = rd_div[c];
                    default:  prdata = '0;
                endcase
            end
        end
    end

    assign pready  = 1'b1;
    assign pslverr = bad;

    // R13: an error response only appears in an access phase
    p_err_access_r13: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (psel && penable));

    // R13: an error response never carries read data
    p_err_no_data_r13: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (prdata == '0));
endmodule

// File: tb/tb_dual_timer_apb.sv
module tb_dual_timer_apb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tick_en = 1'b1;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [1:0]  irq;

    int  tests = 0, fails = 0;
    bit  done = 0;
    bit  tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    int m_run[2], m_os[2], m_ie[2], m_flag[2], m_cnt[2];
    int m_ia[2], m_is[2], m_da[2], m_ds[2], m_ph[2];

    always #10 clk = ~clk;

    dual_timer_apb dut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .tick_en(tick_en),
        .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    task automatic check(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit m_map(input int a, output int ch, output int r);
        int off;
        ch  = a / 32;
        off = a % 32;
        r   = off / 4;
        return (ch < 2) && (off % 4 == 0) && (off <= 16);
    endfunction

    function automatic void m_read(input int a, output int d, output int e);
        int ch, r;
        d = 0; e = 0;
        if (!m_map(a, ch, r)) begin
            e = 1;
            return;
        end
        case (r)
            0: d = m_run[ch] + 2 * m_os[ch] + 4 * m_ie[ch];
            1: d = m_flag[ch];
            2: d = m_is[ch];
            3: d = m_cnt[ch];
            default: d = m_ds[ch];
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_run[c] = 0; m_os[c] = 0; m_ie[c] = 0; m_flag[c] = 0; m_cnt[c] = 0;
                m_ia[c] = 0; m_is[c] = 0; m_da[c] = 0; m_ds[c] = 0; m_ph[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int ch, r, nx, n_run, n_cnt, n_ph, n_da, n_ia, n_flag;
                bit wr, tk, hit;
                wr = psel && penable && pwrite && m_map(int'(paddr), ch, r) && (ch == c);
                n_run = m_run[c]; n_cnt = m_cnt[c]; n_ph = m_ph[c];
                n_da = m_da[c]; n_ia = m_ia[c]; n_flag = m_flag[c];
                tk = 0; hit = 0;
                if (m_run[c] == 0) begin
                    n_ph = 0; n_da = m_ds[c]; n_ia = m_is[c];
                end else if (tick_en) begin
                    if (m_ph[c] == m_da[c]) begin
                        n_ph = 0; n_da = m_ds[c]; tk = 1;
                    end else begin
                        n_ph = m_ph[c] + 1;
                    end
                end
                if (tk) begin
                    nx = (m_cnt[c] + 1) % 65536;
                    if (nx == m_ia[c]) begin
                        hit = 1; n_ia = m_is[c];
                        if (m_os[c] != 0) begin
                            n_cnt = nx; n_run = 0;
                        end else begin
                            n_cnt = 0;
                        end
                    end else begin
                        n_cnt = nx;
                    end
                end
                if (wr && r == 1 && pwdata[0]) n_flag = 0;
                if (hit) n_flag = 1;
                if (wr && r == 0) begin
                    if (pwdata[0] && m_run[c] == 0) n_cnt = 0;
                    n_run = pwdata[0];
                    m_os[c] = pwdata[1];
                    m_ie[c] = pwdata[2];
                end
                if (wr && r == 2) m_is[c] = int'(pwdata[15:0]);
                if (wr && r == 4) m_ds[c] = int'(pwdata[7:0]);
                m_run[c] = n_run; m_cnt[c] = n_cnt; m_ph[c] = n_ph;
                m_da[c] = n_da; m_ia[c] = n_ia; m_flag[c] = n_flag;
            end
        end
    end

    // tick qualifier pattern and per-clock comparison
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en = tick_mode ? (lfsr[0] & lfsr[3]) | lfsr[7] : 1'b1;
        if (rst_n && !done) begin
            check("R8 irq ch0", irq[0], (m_flag[0] != 0 && m_ie[0] != 0));
            check("R8 irq ch1", irq[1], (m_flag[1] != 0 && m_ie[1] != 0));
            check("R13 pready", pready, 1);
        end
    end

    task automatic apb_write(int a, int d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = 8'(a); pwdata = 32'(d);
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(int a, string tag, output int got);
        int ed, ee;
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = 8'(a);
        @(negedge clk);
        penable = 1;
        #1;
        got = int'(prdata);
        m_read(a, ed, ee);
        check({tag, " data"}, prdata, ed);
        check({tag, " pslverr"}, pslverr, ee);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wait_irq(int c, int limit, output int k);
        k = 0;
        while (!irq[c] && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, k, c1, c2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq after reset", irq, 0);
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 5; r++) begin
                apb_read(c * 32 + r * 4, "R1 reset read", v);
                check("R1 reset value", v, 0);
            end
        // R2 read-back, count not writable
        apb_write(8'h00, 32'hFFFF_FFF4);
        apb_write(8'h08, 32'h1234_ABCD);
        apb_write(8'h10, 32'h0000_01A7);
        apb_write(8'h0C, 32'h0000_5555);
        apb_read(8'h00, "R2 ctrl", v); check("R2 ctrl bits", v, 4);
        apb_read(8'h08, "R2 ival", v); check("R2 ival bits", v, 16'hABCD);
        apb_read(8'h10, "R2 div", v);  check("R2 div bits", v, 8'hA7);
        apb_read(8'h0C, "R2 cnt", v);  check("R2 cnt read-only", v, 0);
        apb_read(8'h20, "R12 ch1 untouched", v); check("R12 ch1 ctrl", v, 0);
        // R3 R5 exact first-match timing
        apb_write(8'h10, 2);
        apb_write(8'h08, 5);
        apb_write(8'h00, 5);
        wait_irq(0, 100, k);
        check("R3 first match cycles", k, 15);
        apb_read(8'h00, "R6 still running", v); check("R6 run bit", v & 1, 1);
        repeat (20) @(negedge clk);
        apb_read(8'h0C, "R6 count after reload", v);
        apb_write(8'h00, 0);
        apb_write(8'h04, 1);
        // R7 one-shot on ch1, R9 clear behaviour
        apb_write(8'h30, 0);
        apb_write(8'h28, 4);
        apb_write(8'h20, 7);
        wait_irq(1, 100, k);
        check("R7 one-shot match cycles", k, 4);
        apb_read(8'h2C, "R7 held count", v); check("R7 count at interval", v, 4);
        apb_read(8'h20, "R7 ctrl", v);       check("R7 run cleared", v, 6);
        apb_write(8'h24, 0);
        apb_read(8'h24, "R9 write 0", v);    check("R9 flag kept", v, 1);
        apb_write(8'h24, 1);
        apb_read(8'h24, "R9 write 1", v);    check("R9 flag cleared", v, 0);
        check("R9 irq low", irq[1], 0);
        // R5 interval 0 wraps after 65536 ticks
        apb_write(8'h28, 0);
        apb_write(8'h20, 5);
        wait_irq(1, 70000, k);
        check("R5 zero interval cycles", k, 65536);
        apb_write(8'h20, 0);
        apb_write(8'h24, 1);
        // R9 set wins over clear: match on every cycle
        apb_write(8'h10, 0);
        apb_write(8'h08, 1);
        apb_write(8'h00, 5);
        repeat (4) @(negedge clk);
        apb_write(8'h04, 1);
        apb_read(8'h04, "R9 set wins", v); check("R9 flag stays set", v, 1);
        apb_write(8'h00, 4);
        apb_write(8'h04, 1);
        apb_read(8'h04, "R9 cleared when idle", v); check("R9 flag clear", v, 0);
        // R11 stop holds count, R4 restart from zero
        apb_write(8'h10, 255);
        apb_write(8'h08, 1000);
        apb_write(8'h00, 1);
        repeat (2000) @(negedge clk);
        apb_write(8'h00, 0);
        apb_read(8'h0C, "R11 count a", c1);
        repeat (50) @(negedge clk);
        apb_read(8'h0C, "R11 count b", c2);
        check("R11 count held", c2, c1);
        check("R11 count nonzero", (c1 > 0), 1);
        apb_write(8'h00, 1);
        apb_read(8'h0C, "R4 restart", v); check("R4 count cleared", v, 0);
        apb_write(8'h00, 0);
        // R10 interval shadow while running
        apb_write(8'h10, 0);
        apb_write(8'h08, 100);
        apb_write(8'h00, 1);
        repeat (10) @(negedge clk);
        apb_write(8'h08, 20);
        repeat (30) @(negedge clk);
        apb_read(8'h0C, "R10 old interval active", v);
        check("R10 passed new interval", (v > 20), 1);
        apb_write(8'h10, 3);
        repeat (200) @(negedge clk);
        apb_read(8'h0C, "R10 after swap", v);
        apb_write(8'h00, 0);
        apb_write(8'h04, 1);
        // R12 both channels with random ticks
        tick_mode = 1;
        apb_write(8'h10, 2);  apb_write(8'h08, 9);  apb_write(8'h00, 5);
        apb_write(8'h30, 0);  apb_write(8'h28, 13); apb_write(8'h20, 7);
        for (int i = 0; i < 60; i++) begin
            repeat (17 + (i % 7) * 5) @(negedge clk);
            apb_read(8'h0C, "R12 ch0 count", v);
            apb_read(8'h2C, "R12 ch1 count", v);
            if (i % 3 == 0) apb_write(8'h04, 1);
            if (i % 4 == 1) apb_write(8'h24, 1);
            if (i % 5 == 2) apb_write(8'h20, 7);
            if (i % 9 == 4) apb_write(8'h08, 3 + i % 11);
        end
        tick_mode = 0;
        // R13 unmapped offsets
        apb_read(8'h14, "R13 hole", v);
        apb_read(8'h40, "R13 no channel", v);
        apb_read(8'h02, "R13 misaligned", v);
        apb_write(8'h40, 32'hFFFF_FFFF);
        apb_write(8'h1C, 32'hFFFF_FFFF);
        apb_read(8'h28, "R13 ch1 ival unchanged", v);
        apb_read(8'h10, "R13 ch0 div unchanged", v);
        repeat (5) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule